// File: doc/BRIEF.md
# Cascadable Half-Digit Decade Counter

This block is a synchronous decimal event counter with four BCD decades and one extra overflow digit, so it can show values from 0 up to 19999. It samples an already clean count strobe on a system clock. Each high-to-low transition of that strobe adds one to the count. An active-low inhibit stops the first decade from stepping. It does this without gating the strobe, so a strobe that changes while counting is held off can never produce a spurious count.

When the four decades roll over from 9999 to 0000, two things happen. A sticky half-digit flag is set, and an active-low carry output pulses low for one clock. That pulse gives the falling edge a following counter stage needs on its own strobe input. The half-digit flag stays set until the active-low clear input is asserted, and the decades keep counting and wrapping after it is set.

Several counters can be cascaded by feeding one stage's carry output into the next stage's strobe input. Digit decoding and display driving are left to the surrounding logic.

Top module: `hdc_counter`

## Requirements
- R1: While `clr_n` is sampled low at a clock edge, that edge sets every digit to 0, clears `half_o` and drives `carry_n_o` high. The clear wins over a strobe edge and over the inhibit in the same cycle. A strobe that is held low across the release of `clr_n` adds no count.
- R2: The count rises by exactly one at the first clock edge where `strobe_i` is sampled low after it was sampled high. Rising edges of the strobe, and a strobe held at either level, leave the count unchanged.
- R3: Each decade holds a BCD value from 0 to 9. A decade steps only at a count event in which every lower decade wraps from 9 to 0.
- R4: `carry_n_o` is high by default. It is low during exactly the one clock cycle whose edge took the decades from 9999 to 0000, and it is high again in the following cycle.
- R5: The first 9999-to-0000 wrap sets `half_o` to 1. The flag stays at 1 until a clear. The decades keep counting and wrapping after the flag is set, and later wraps still pulse `carry_n_o`.
- R6: While `inhibit_n` is low, strobe falling edges do not change the count. A strobe that fell during the inhibit and is still low when the inhibit is released also adds no count.
- R7: Decade k (k = 0 is least significant) appears on `digits_o[4k+3:4k]` as an unsigned BCD value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| clr_n | input | 1 | Active-low synchronous clear of the whole counter (inactive level is high) |
| strobe_i | input | 1 | Clean count strobe; each falling edge is one count |
| inhibit_n | input | 1 | Active-low hold of the first decade (inactive level is high) |
| digits_o | output | 16 | Four BCD decades, least significant decade in bits 3:0 |
| half_o | output | 1 | Sticky half-digit overflow flag |
| carry_n_o | output | 1 | Active-low one-cycle carry pulse on a 9999-to-0000 wrap |

## Verification
Two pairs of functions can land on the same clock edge, and both are provoked on purpose.

The first pair is the clear and a counted strobe edge. The bench drives `clr_n` and `strobe_i` low in the same cycle. It expects all zeros afterwards, and it expects no count when the strobe stays low while the clear is released.

The second pair is the release of the inhibit and a strobe that already fell while counting was held off. The bench releases `inhibit_n` with the strobe still low. It judges that the count is unchanged until the next real falling edge, which must then add exactly one.

The 9999-to-0000 wrap is run twice. This checks that the carry pulse and the half-digit flag are set together the first time, and that the carry pulses again while the flag merely holds the second time.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  localparam int BCD_W   = 4;
  localparam int BCD_TOP = 9;

  typedef logic [BCD_W-1:0] bcd_t;

  // next value of one decade, wrapping after the top digit
  function automatic bcd_t bcd_step(input bcd_t d);
    bcd_t r;
    if (d >= bcd_t'(BCD_TOP)) r = '0;
    else                      r = d + bcd_t'(1);
    return r;
  endfunction

  // true when a step applied to this decade makes it wrap
  function automatic logic bcd_wraps(input bcd_t d);
    return (d == bcd_t'(BCD_TOP));
  endfunction
endpackage

// File: rtl/hdc_strobe_edge.sv
module hdc_strobe_edge (
  input  logic clk,
  input  logic clr_n,
  input  logic strobe_i,
  input  logic inhibit_n,
  output logic fall_o,
  output logic step_o
);
  logic strobe_prev_q;

  // previous sampled strobe level; during clear it follows the input so a
  // strobe held low across clear release is not seen as a new edge
  always_ff @(posedge clk) begin
    strobe_prev_q <= strobe_i;
  end

  assign fall_o = clr_n & strobe_prev_q & ~strobe_i;
  // the inhibit acts on the first stage's enable, not on the strobe path
  assign step_o = fall_o & inhibit_n;

  // R2: a fall event needs the strobe to have been high on the previous edge
  p_fall_needs_high_r2: assert property (@(posedge clk) disable iff (!clr_n)
    fall_o |-> $past(strobe_i));
endmodule

// File: rtl/hdc_decade.sv
module hdc_decade
  import hdc_pkg::*;
(
  input  logic clk,
  input  logic clr_n,
  input  logic step_i,
  output bcd_t digit_o,
  output logic wrap_o
);
  bcd_t digit_q;

  always_ff @(posedge clk) begin
    if (!clr_n)      digit_q <= '0;
    else if (step_i) digit_q <= bcd_step(digit_q);
  end

  assign digit_o = digit_q;
  assign wrap_o  = step_i & bcd_wraps(digit_q);

  // R3: decade value stays within BCD range
  p_bcd_range_r3: assert property (@(posedge clk) disable iff (!clr_n)
    digit_q <= bcd_t'(BCD_TOP));

  // R3: without a step from below, the decade holds
  p_hold_without_step_r3: assert property (@(posedge clk) disable iff (!clr_n)
    !step_i |=> $stable(digit_q));

  // R3: a stepped decade that did not wrap moved away from its old value
  p_step_moves_r3: assert property (@(posedge clk) disable iff (!clr_n)
    step_i |=> !$stable(digit_q));
endmodule

// File: rtl/hdc_overflow.sv
module hdc_overflow (
  input  logic clk,
  input  logic clr_n,
  input  logic wrap_i,
  output logic half_o,
  output logic carry_n_o
);
  logic half_q;
  logic carry_n_q;

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      half_q    <= 1'b0;
      carry_n_q <= 1'b1;
    end else begin
      carry_n_q <= ~wrap_i;
      if (wrap_i) half_q <= 1'b1;
    end
  end

  assign half_o    = half_q;
  assign carry_n_o = carry_n_q;

  // R5: the half-digit flag is sticky until clear
  p_half_sticky_r5: assert property (@(posedge clk) disable iff (!clr_n)
    half_q |=> half_q);

  // R4: the carry pulse lasts a single cycle
  p_carry_single_r4: assert property (@(posedge clk) disable iff (!clr_n)
    !carry_n_q |=> carry_n_q);

  // R5: a carry pulse always comes with the flag set
  p_carry_sets_half_r5: assert property (@(posedge clk) disable iff (!clr_n)
    !carry_n_q |-> half_q);
endmodule

// File: rtl/hdc_counter.sv
module hdc_counter
  import hdc_pkg::*;
#(
  parameter int NUM_DECADES = 4
) (
  input  logic                         clk,
  input  logic                         clr_n,
  input  logic                         strobe_i,
  input  logic                         inhibit_n,
  output logic [NUM_DECADES*BCD_W-1:0] digits_o,
  output logic                         half_o,
  output logic                         carry_n_o
);
  localparam int DIG_BITS = NUM_DECADES * BCD_W;

  // named internal events for the assertions
  logic                 strobe_fall;
  logic                 count_step;
  logic [NUM_DECADES:0] step_chain;
  logic                 full_wrap;

  hdc_strobe_edge u_edge (
    .clk       (clk),
    .clr_n     (clr_n),
    .strobe_i  (strobe_i),
    .inhibit_n (inhibit_n),
    .fall_o    (strobe_fall),
    .step_o    (count_step)
  );

  assign step_chain[0] = count_step;

  for (genvar k = 0; k < NUM_DECADES; k++) begin : g_decade
    bcd_t digit_k;
    hdc_decade u_dec (
      .clk     (clk),
      .clr_n   (clr_n),
      .step_i  (step_chain[k]),
      .digit_o (digit_k),
      .wrap_o  (step_chain[k+1])
    );
    assign digits_o[k*BCD_W +: BCD_W] = digit_k;
  end

  assign full_wrap = step_chain[NUM_DECADES];

  hdc_overflow u_ovf (
    .clk       (clk),
    .clr_n     (clr_n),
    .wrap_i    (full_wrap),
    .half_o    (half_o),
    .carry_n_o (carry_n_o)
  );

  // R1: clear gives zero digits, no flag, carry idle
  p_clear_state_r1: assert property (@(posedge clk)
    !clr_n |=> (digits_o == '0 && !half_o && carry_n_o));

  // R2: a strobe sampled high never counts on that edge
  p_high_no_count_r2: assert property (@(posedge clk) disable iff (!clr_n)
    strobe_i |=> $stable(digits_o));

  // R6: inhibit freezes the count
  p_inhibit_hold_r6: assert property (@(posedge clk) disable iff (!clr_n)
    !inhibit_n |=> $stable(digits_o));

  // R6: a fall during inhibit is not a step
  p_inhibit_blocks_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (strobe_fall && !inhibit_n) |=> $stable(digits_o));

  // R4: the carry pulse shows the wrapped all-zero count
  p_carry_at_zero_r4: assert property (@(posedge clk) disable iff (!clr_n)
    !carry_n_o |-> (digits_o == DIG_BITS'(0)));

  // R4: carry goes low only right after a full wrap event
  p_carry_cause_r4: assert property (@(posedge clk) disable iff (!clr_n)
    $fell(carry_n_o) |-> $past(full_wrap));
endmodule

// File: tb/test_hdc_counter.sv
module test_hdc_counter;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 9;

  // row: {inhibit_n, pulses[15:0], expected total count[16:0]}
  localparam logic [33:0] VEC [NROWS] = '{
    {1'b1, 16'd1,    17'd1},
    {1'b1, 16'd8,    17'd9},
    {1'b1, 16'd1,    17'd10},
    {1'b0, 16'd5,    17'd10},
    {1'b1, 16'd89,   17'd99},
    {1'b1, 16'd1,    17'd100},
    {1'b1, 16'd899,  17'd999},
    {1'b1, 16'd1,    17'd1000},
    {1'b1, 16'd8999, 17'd9999}
  };

  logic        clk = 1'b0;
  logic        clr_n = 1'b0;
  logic        strobe = 1'b1;
  logic        inhibit_n = 1'b1;
  logic [15:0] digits;
  logic        half;
  logic        carry_n;

  int checks = 0;
  int bad = 0;
  int carry_lows = 0;
  int carry_long = 0;
  logic carry_prev_low = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdc_counter i_hdc_counter (
    .clk       (clk),
    .clr_n     (clr_n),
    .strobe_i  (strobe),
    .inhibit_n (inhibit_n),
    .digits_o  (digits),
    .half_o    (half),
    .carry_n_o (carry_n)
  );

  // monitor of carry pulses, sampled away from the active edge
  always @(negedge clk) begin
    if (clr_n && !carry_n) begin
      carry_lows++;
      if (carry_prev_low) carry_long++;
    end
    carry_prev_low = clr_n && !carry_n;
  end

  function automatic logic [15:0] to_bcd(input int value);
    logic [15:0] r;
    int v;
    v = value % 10000;
    for (int i = 0; i < 4; i++) begin
      r[i*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_count(input string req, input int total);
    check({req, " digits"}, int'(digits), int'(to_bcd(total)));
    check({req, " half"}, int'(half), (total >= 10000) ? 1 : 0);
  endtask

  // one strobe pulse: fall, one cycle low, back high; samples at negedges
  logic saw_carry_low;
  task automatic pulse();
    strobe = 1'b0;
    @(negedge clk);
    saw_carry_low = !carry_n;
    strobe = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int total;
    int wraps_before;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_count("R1 reset", 0);
    check("R1 reset carry", int'(carry_n), 1);
    clr_n = 1'b1;
    @(negedge clk);
    check_count("R1 idle after release", 0);

    // table walk (R2, R3, R6, R7)
    total = 0;
    for (int r = 0; r < NROWS; r++) begin
      inhibit_n = VEC[r][33];
      for (int p = 0; p < int'(VEC[r][32:17]); p++) pulse();
      inhibit_n = 1'b1;
      total = int'(VEC[r][16:0]);
      check_count($sformatf("R3 R7 row %0d", r), total);
    end
    check("R4 no carry before wrap", carry_lows, 0);

    // R4/R5: first wrap, carry low in the wrap cycle only
    pulse();
    check("R4 carry low at wrap", int'(saw_carry_low), 1);
    check("R4 carry high after wrap", int'(carry_n), 1);
    check_count("R5 first wrap", 10000);
    check("R4 one carry pulse", carry_lows, 1);

    // R5: keep counting with flag set, second wrap
    for (int p = 0; p < 9999; p++) pulse();
    check_count("R5 counting after flag", 19999);
    wraps_before = carry_lows;
    pulse();
    check("R5 second carry", int'(saw_carry_low), 1);
    check("R5 flag holds", int'(half), 1);
    check("R5 digits wrapped", int'(digits), 0);
    check("R4 carry pulses counted", carry_lows, wraps_before + 1);
    check("R4 pulses one cycle wide", carry_long, 0);

    // R1: clear and strobe fall in the same cycle
    clr_n = 1'b0;
    strobe = 1'b0;
    @(negedge clk);
    check_count("R1 clear beats fall", 0);
    check("R1 clear carry", int'(carry_n), 1);
    clr_n = 1'b1;
    repeat (2) @(negedge clk);
    check_count("R1 held strobe after clear", 0);
    strobe = 1'b1;
    @(negedge clk);
    check_count("R2 rising edge ignored", 0);
    pulse();
    check_count("R2 single count", 1);

    // R6: inhibit with pulses, then release with strobe still low
    inhibit_n = 1'b0;
    repeat (3) pulse();
    check_count("R6 inhibited pulses", 1);
    strobe = 1'b0;
    repeat (2) @(negedge clk);
    inhibit_n = 1'b1;
    repeat (3) @(negedge clk);
    check_count("R6 release with strobe low", 1);
    strobe = 1'b1;
    @(negedge clk);
    pulse();
    check_count("R6 count after release", 2);

    // R2: strobe level held high over many cycles
    repeat (5) @(negedge clk);
    check_count("R2 level no count", 2);

    finish_run();
  end
endmodule